// File: doc/BRIEF.md
# Real-mode interrupt entry sequencer

This control unit sits beside an instruction pipeline and acts at each instruction boundary. When the boundary strobe is high, the request line is high and the interrupt-enable bit of the flags word is set, it saves the minimum context on the stack and redirects execution. The context is the flags word, the code segment and the instruction pointer. It then obtains an 8-bit vector number from an interrupt controller through a request/acknowledge pair. From the vector table it reads a two-word entry: the low word becomes the new instruction pointer and the high word becomes the new code segment.

A return request runs the reverse sequence. It pops the instruction pointer, then the code segment, then the flags word. Every memory access is one 16-bit word on a request/acknowledge port. A stack address is the stack segment shifted left by four plus the stack pointer, truncated to 20 bits. A vector entry sits at the vector number times four, in a table that starts at address 0. When a sequence finishes, the new code segment, instruction pointer, flags word and stack pointer appear on registered outputs, and `done` is high for one cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `inta_req` are all 0.
- R2: While `instr_done` is low, a high `intr` starts nothing: `busy`, `mem_req` and `inta_req` stay 0.
- R3: A boundary with `intr` high and flags bit 9 (interrupt enable) at 0 starts nothing, even when bit 8 (trap) is set.
- R4: An accepted interrupt issues three word writes in this order: the captured flags at SS*16+SP-2, the captured CS at SS*16+SP-4, and the captured IP at SS*16+SP-6. Each request is held, with a stable address, until `mem_ack`.
- R5: After the third push, `inta_req` rises and stays high until `inta_ack`. No memory request is made while it is high. `inta_vec` is taken on the acknowledge cycle.
- R6: After the acknowledge, two word reads follow: one at vector*4 (the new IP) and one at vector*4+2 (the new CS).
- R7: At the end of entry, `done` pulses for one cycle. In that cycle the outputs hold: IP = low vector word, CS = high vector word, flags = the captured flags with bits 9 and 8 cleared, SP = SP-6.
- R8: A return request issues reads at SS*16+SP (IP), SS*16+SP+2 (CS) and SS*16+SP+4 (flags). It ends with `done` and the outputs IP, CS, flags as read, and SP+6.
- R9: `busy` is high from the cycle after acceptance until the final acknowledge. It is low in the `done` cycle, and `done` lasts exactly one cycle. Boundary strobes and return requests that arrive while `busy` is high start no further transaction.
- R10: SP arithmetic wraps modulo 2^16 and physical addresses wrap modulo 2^20. With SS=0xFFFF and SP=0, the first push lands at 0x0FFEE.
- R11: When `ret_req` and an interrupt that would be accepted arrive in the same idle cycle, the return sequence is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Instruction boundary strobe |
| intr | input | 1 | Maskable external interrupt request |
| ret_req | input | 1 | Request to run the return sequence |
| flags_in | input | 16 | Current flags word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory transaction complete |
| inta_req | output | 1 | Vector number request to the interrupt controller |
| inta_ack | input | 1 | Vector number valid |
| inta_vec | input | 8 | Vector number |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| cs_out | output | 16 | New code segment |
| ip_out | output | 16 | New instruction pointer |
| flags_out | output | 16 | New flags word |
| sp_out | output | 16 | New stack pointer |

## Verification
The bench builds the block with its default parameters: 16-bit words, 20-bit physical addresses, a segment shift of four and an 8-bit vector number. These values make the two wrap boundaries reachable directly, and the bench exercises both. A stack pointer of zero with segment 0xFFFF crosses the 16-bit pointer wrap and the 20-bit address wrap on the same push. Vector 0xFF reaches the last entry of the 1 KB table. The interrupt controller answers after several programmed delays, so the wait state is observed both briefly and for many cycles. The return that follows an entry reads back the words the entry pushed.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH_F,
    S_PUSH_CS,
    S_PUSH_IP,
    S_INTA,
    S_VEC_LO,
    S_VEC_HI,
    S_POP_IP,
    S_POP_CS,
    S_POP_F
  } seq_state_e;

  function automatic logic is_push(input seq_state_e s);
    return (s == S_PUSH_F) || (s == S_PUSH_CS) || (s == S_PUSH_IP);
  endfunction

  function automatic logic is_pop(input seq_state_e s);
    return (s == S_POP_IP) || (s == S_POP_CS) || (s == S_POP_F);
  endfunction

  function automatic logic is_vec(input seq_state_e s);
    return (s == S_VEC_LO) || (s == S_VEC_HI);
  endfunction

endpackage

// File: rtl/irq_phys_addr.sv
module irq_phys_addr #(
  parameter int ADDR_W    = 20,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [OFF_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);
  logic [ADDR_W-1:0] seg_base;

  always_comb begin
    seg_base = ADDR_W'(seg) << SEG_SHIFT;
    phys     = seg_base + ADDR_W'(off);
  end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int ADDR_W     = 20,
  parameter int VEC_W      = 8,
  parameter int WORD_BYTES = 2
) (
  input  logic [VEC_W-1:0]  vec,
  input  logic              hi_word,
  output logic [ADDR_W-1:0] addr
);
  localparam int ENTRY_SHIFT = $clog2(2 * WORD_BYTES);

  always_comb begin
    addr = (ADDR_W'(vec) << ENTRY_SHIFT)
         + (hi_word ? ADDR_W'(WORD_BYTES) : '0);
  end
endmodule

// File: rtl/irq_flags_mask.sv
module irq_flags_mask #(
  parameter int W      = 16,
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input  logic [W-1:0] flags_i,
  output logic [W-1:0] flags_o
);
  localparam logic [W-1:0] CLR_MASK = (W'(1) << IF_BIT) | (W'(1) << TF_BIT);

  assign flags_o = flags_i & ~CLR_MASK;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int VEC_W     = 8,
  parameter int SEG_SHIFT = 4,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_done,
  input  logic              intr,
  input  logic              ret_req,
  input  logic [DATA_W-1:0] flags_in,
  input  logic [DATA_W-1:0] cs_in,
  input  logic [DATA_W-1:0] ip_in,
  input  logic [DATA_W-1:0] ss_in,
  input  logic [DATA_W-1:0] sp_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              inta_req,
  input  logic              inta_ack,
  input  logic [VEC_W-1:0]  inta_vec,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] cs_out,
  output logic [DATA_W-1:0] ip_out,
  output logic [DATA_W-1:0] flags_out,
  output logic [DATA_W-1:0] sp_out
);
  localparam int                WORD_BYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] STEP       = DATA_W'(WORD_BYTES);

  seq_state_e        st_q;
  logic [DATA_W-1:0] cs_q, ip_q, fl_q, ss_q, sp_q;
  logic [DATA_W-1:0] tgt_ip_q, tgt_cs_q;
  logic [VEC_W-1:0]  vec_q;

  logic              take_irq;
  logic [DATA_W-1:0] stk_off;
  logic [ADDR_W-1:0] stk_addr, vec_addr;
  logic [DATA_W-1:0] fl_cleared;
  logic              xfer;

  assign take_irq = instr_done && intr && flags_in[IF_BIT];
  assign stk_off  = is_push(st_q) ? (sp_q - STEP) : sp_q;

  irq_phys_addr #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (DATA_W),
    .SEG_SHIFT(SEG_SHIFT)
  ) u_stk_addr (
    .seg (ss_q),
    .off (stk_off),
    .phys(stk_addr)
  );

  irq_vec_addr #(
    .ADDR_W    (ADDR_W),
    .VEC_W     (VEC_W),
    .WORD_BYTES(WORD_BYTES)
  ) u_vec_addr (
    .vec    (vec_q),
    .hi_word(st_q == S_VEC_HI),
    .addr   (vec_addr)
  );

  irq_flags_mask #(
    .W     (DATA_W),
    .IF_BIT(IF_BIT),
    .TF_BIT(TF_BIT)
  ) u_fl_mask (
    .flags_i(fl_q),
    .flags_o(fl_cleared)
  );

  // Memory port decoded from registered state only
  always_comb begin
    mem_req   = is_push(st_q) || is_pop(st_q) || is_vec(st_q);
    mem_we    = is_push(st_q);
    mem_addr  = is_vec(st_q) ? vec_addr : stk_addr;
    unique case (st_q)
      S_PUSH_F:  mem_wdata = fl_q;
      S_PUSH_CS: mem_wdata = cs_q;
      S_PUSH_IP: mem_wdata = ip_q;
      default:   mem_wdata = '0;
    endcase
  end

  assign inta_req = (st_q == S_INTA);
  assign xfer     = mem_req && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      cs_q      <= '0;
      ip_q      <= '0;
      fl_q      <= '0;
      ss_q      <= '0;
      sp_q      <= '0;
      tgt_ip_q  <= '0;
      tgt_cs_q  <= '0;
      vec_q     <= '0;
      cs_out    <= '0;
      ip_out    <= '0;
      flags_out <= '0;
      sp_out    <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (ret_req) begin
            ss_q <= ss_in;
            sp_q <= sp_in;
            busy <= 1'b1;
            st_q <= S_POP_IP;
          end else if (take_irq) begin
            fl_q <= flags_in;
            cs_q <= cs_in;
            ip_q <= ip_in;
            ss_q <= ss_in;
            sp_q <= sp_in;
            busy <= 1'b1;
            st_q <= S_PUSH_F;
          end
        end
        S_PUSH_F: if (xfer) begin
          sp_q <= sp_q - STEP;
          st_q <= S_PUSH_CS;
        end
        S_PUSH_CS: if (xfer) begin
          sp_q <= sp_q - STEP;
          st_q <= S_PUSH_IP;
        end
        S_PUSH_IP: if (xfer) begin
          sp_q <= sp_q - STEP;
          st_q <= S_INTA;
        end
        S_INTA: if (inta_ack) begin
          vec_q <= inta_vec;
          st_q  <= S_VEC_LO;
        end
        S_VEC_LO: if (xfer) begin
          tgt_ip_q <= mem_rdata;
          st_q     <= S_VEC_HI;
        end
        S_VEC_HI: if (xfer) begin
          ip_out    <= tgt_ip_q;
          cs_out    <= mem_rdata;
          flags_out <= fl_cleared;
          sp_out    <= sp_q;
          busy      <= 1'b0;
          done      <= 1'b1;
          st_q      <= S_IDLE;
        end
        S_POP_IP: if (xfer) begin
          tgt_ip_q <= mem_rdata;
          sp_q     <= sp_q + STEP;
          st_q     <= S_POP_CS;
        end
        S_POP_CS: if (xfer) begin
          tgt_cs_q <= mem_rdata;
          sp_q     <= sp_q + STEP;
          st_q     <= S_POP_F;
        end
        S_POP_F: if (xfer) begin
          ip_out    <= tgt_ip_q;
          cs_out    <= tgt_cs_q;
          flags_out <= mem_rdata;
          sp_out    <= sp_q + STEP;
          busy      <= 1'b0;
          done      <= 1'b1;
          st_q      <= S_IDLE;
        end
        default: begin
          busy <= 1'b0;
          st_q <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  parameter int IF_BIT = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_done,
  input logic              intr,
  input logic              ret_req,
  input logic [DATA_W-1:0] flags_in,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              inta_req,
  input logic              inta_ack,
  input logic              busy,
  input logic              done
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_req && !inta_req));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ret_req && !(instr_done && intr && flags_in[IF_BIT])) |=> !busy);

  // R4
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R5
  inta_excl_chk: assert property (@(posedge clk) disable iff (rst)
    inta_req |-> !mem_req);

  // R5
  inta_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inta_req && !inta_ack) |=> inta_req);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ret_req || (instr_done && intr && flags_in[IF_BIT])));

  // R9
  req_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req || inta_req) |-> busy);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .IF_BIT(IF_BIT)
) u_chk (.*);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_done = 1'b0, intr = 1'b0, ret_req = 1'b0;
  logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        inta_req;
  logic        inta_ack = 1'b0;
  logic [7:0]  inta_vec = '0;
  logic        busy, done;
  logic [15:0] cs_out, ip_out, flags_out, sp_out;

  always #4 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst(rst), .instr_done(instr_done), .intr(intr), .ret_req(ret_req),
    .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .inta_req(inta_req), .inta_ack(inta_ack),
    .inta_vec(inta_vec), .busy(busy), .done(done), .cs_out(cs_out), .ip_out(ip_out),
    .flags_out(flags_out), .sp_out(sp_out)
  );

  typedef struct { bit we; logic [19:0] addr; logic [15:0] data; string tag; } txn_t;
  typedef struct { logic [15:0] cs; logic [15:0] ip; logic [15:0] fl; logic [15:0] sp; string tag; } res_t;

  txn_t        txq[$];
  res_t        rsq[$];
  logic [15:0] mem [int unsigned];
  int          n_chk = 0, n_fail = 0;
  int          inta_delay = 0, inta_cnt = 0;
  logic [7:0]  vec_cfg = '0;
  bit          finished = 0;
  txn_t        cur_t;
  res_t        cur_r;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] ss, input logic [15:0] sp);
    return 20'(({4'b0, ss} << 4) + {4'b0, sp});
  endfunction

  // Memory model, interrupt controller model and scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      mem_ack  = 1'b0;
      inta_ack = 1'b0;
    end else begin
      if (mem_req && !mem_ack) begin
        if (txq.size() == 0) begin
          check(1'b0, "R9", "unexpected memory transaction", {12'b0, mem_addr}, 32'hFFFF_FFFF);
        end else begin
          cur_t = txq.pop_front();
          check(mem_we == cur_t.we, cur_t.tag, "direction", {31'b0, mem_we}, {31'b0, cur_t.we});
          check(mem_addr == cur_t.addr, cur_t.tag, "address", {12'b0, mem_addr}, {12'b0, cur_t.addr});
          if (cur_t.we)
            check(mem_wdata == cur_t.data, cur_t.tag, "write data", {16'b0, mem_wdata}, {16'b0, cur_t.data});
        end
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        else mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
        mem_ack = 1'b1;
      end else begin
        mem_ack = 1'b0;
      end

      if (inta_req && !inta_ack) begin
        check(!mem_req, "R5", "memory request during vector wait", {31'b0, mem_req}, 32'd0);
        if (inta_cnt >= inta_delay) begin
          inta_ack = 1'b1;
          inta_vec = vec_cfg;
          inta_cnt = 0;
        end else begin
          inta_cnt++;
        end
      end else begin
        inta_ack = 1'b0;
      end

      if (done) begin
        if (rsq.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
        end else begin
          cur_r = rsq.pop_front();
          check(ip_out == cur_r.ip, cur_r.tag, "ip_out", {16'b0, ip_out}, {16'b0, cur_r.ip});
          check(cs_out == cur_r.cs, cur_r.tag, "cs_out", {16'b0, cs_out}, {16'b0, cur_r.cs});
          check(flags_out == cur_r.fl, cur_r.tag, "flags_out", {16'b0, flags_out}, {16'b0, cur_r.fl});
          check(sp_out == cur_r.sp, cur_r.tag, "sp_out", {16'b0, sp_out}, {16'b0, cur_r.sp});
        end
      end
    end
  end

  task automatic exp_txn(input bit we, input logic [19:0] a, input logic [15:0] d, input string tag);
    txn_t t;
    t.we = we; t.addr = a; t.data = d; t.tag = tag;
    txq.push_back(t);
  endtask

  task automatic exp_res(input logic [15:0] cs, input logic [15:0] ip, input logic [15:0] fl,
                         input logic [15:0] sp, input string tag);
    res_t r;
    r.cs = cs; r.ip = ip; r.fl = fl; r.sp = sp; r.tag = tag;
    rsq.push_back(r);
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (!done && k < 2000) begin
      @(negedge clk);
      k++;
    end
    check(done, tag, "done seen", {31'b0, done}, 32'd1);
    check(!busy, "R9", "busy low with done", {31'b0, busy}, 32'd0);
    @(negedge clk);
    check(!done && !busy, "R9", "done one cycle, idle after", {30'b0, done, busy}, 32'd0);
  endtask

  task automatic quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!busy && !mem_req && !inta_req, tag, "no activity",
            {29'b0, busy, mem_req, inta_req}, 32'd0);
    end
  endtask

  // Driver: predicts the entry sequence, then raises the boundary strobe
  task automatic run_entry(input logic [15:0] fl, input logic [15:0] cs, input logic [15:0] ip,
                           input logic [15:0] ss, input logic [15:0] sp, input logic [7:0] vec,
                           input int dly, input logic [15:0] vlo, input logic [15:0] vhi,
                           input bit poke, input string wtag);
    logic [19:0] va;
    va = {10'b0, vec, 2'b00};
    mem[int'(va)]      = vlo;
    mem[int'(va + 2)]  = vhi;
    exp_txn(1'b1, phys(ss, 16'(sp - 16'd2)), fl, wtag);
    exp_txn(1'b1, phys(ss, 16'(sp - 16'd4)), cs, wtag);
    exp_txn(1'b1, phys(ss, 16'(sp - 16'd6)), ip, wtag);
    exp_txn(1'b0, va, 16'h0, "R6");
    exp_txn(1'b0, va + 20'd2, 16'h0, "R6");
    exp_res(vhi, vlo, fl & 16'hFCFF, 16'(sp - 16'd6), "R7");
    inta_delay = dly;
    vec_cfg    = vec;
    @(negedge clk);
    flags_in = fl; cs_in = cs; ip_in = ip; ss_in = ss; sp_in = sp;
    instr_done = 1'b1; intr = 1'b1;
    @(negedge clk);
    instr_done = 1'b0; intr = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      instr_done = 1'b1; intr = 1'b1; ret_req = 1'b1;
      @(negedge clk);
      instr_done = 1'b0; intr = 1'b0; ret_req = 1'b0;
    end
    wait_done("R7");
  endtask

  // Driver: predicts the return sequence; with_irq also offers an interrupt in the same cycle
  task automatic run_ret(input logic [15:0] ss, input logic [15:0] sp, input logic [15:0] e_ip,
                         input logic [15:0] e_cs, input logic [15:0] e_fl, input bit with_irq,
                         input string tag);
    exp_txn(1'b0, phys(ss, sp), 16'h0, tag);
    exp_txn(1'b0, phys(ss, 16'(sp + 16'd2)), 16'h0, tag);
    exp_txn(1'b0, phys(ss, 16'(sp + 16'd4)), 16'h0, tag);
    exp_res(e_cs, e_ip, e_fl, 16'(sp + 16'd6), "R8");
    @(negedge clk);
    ss_in = ss; sp_in = sp;
    ret_req = 1'b1;
    if (with_irq) begin
      flags_in = 16'h0200; instr_done = 1'b1; intr = 1'b1;
    end
    @(negedge clk);
    ret_req = 1'b0; instr_done = 1'b0; intr = 1'b0;
    wait_done("R8");
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!busy && !done && !mem_req && !inta_req, "R1", "reset state",
          {28'b0, busy, done, mem_req, inta_req}, 32'd0);

    // R2: request without boundary strobe
    flags_in = 16'h0200; intr = 1'b1;
    quiet("R2", 6);
    intr = 1'b0;

    // R3: boundary with interrupts disabled, trap set
    flags_in = 16'h0100; intr = 1'b1; instr_done = 1'b1;
    quiet("R3", 4);
    intr = 1'b0; instr_done = 1'b0;
    quiet("R3", 2);

    // R4 R5 R6 R7: plain entry, controller answers after 3 cycles
    run_entry(16'h0346, 16'h1234, 16'h5678, 16'h2000, 16'h0100, 8'h1C, 3,
              16'hABCD, 16'hF000, 1'b0, "R4");

    // R8: return from that entry
    run_ret(16'h2000, 16'h00FA, 16'h5678, 16'h1234, 16'h0346, 1'b0, "R8");

    // R10: stack pointer and physical wrap, last vector, immediate answer
    run_entry(16'h0200, 16'hAAAA, 16'h5555, 16'hFFFF, 16'h0000, 8'hFF, 0,
              16'h1111, 16'h2222, 1'b0, "R10");

    // R11: return and interrupt together, return wins; pops wrap SP back to 0
    run_ret(16'hFFFF, 16'hFFFA, 16'h5555, 16'hAAAA, 16'h0200, 1'b1, "R11");

    // R9: triggers during a running sequence, long controller wait
    run_entry(16'h0300, 16'h0F0F, 16'h00F0, 16'h3000, 16'h0200, 8'h08, 12,
              16'h1357, 16'h2468, 1'b1, "R4");
    quiet("R9", 4);

    check(txq.size() == 0, "R6", "pending transactions", txq.size(), 32'd0);
    check(rsq.size() == 0, "R7", "pending results", rsq.size(), 32'd0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=completion");
      summary();
      $finish;
    end
  end

endmodule